// File: doc/BRIEF.md
# Low-Power Wait/Stop Mode Controller

This block holds the low-power state of a small 8-bit microcontroller and produces the clock enables for the CPU, the free-running timer, the on-chip peripherals and the oscillator. A one-cycle request from the CPU moves the block from run into wait or stop. An unmasked pending interrupt brings it back. Wait stops only the CPU clock. While the block is in wait, it requests a read on every bus cycle from the address where the status register was stacked. Stop turns every clock off, the oscillator included. RAM contents are kept because the block only gates clocks.

The block has four named states. `ST_RUN` is normal execution. `ST_WAIT` is the CPU-halted wait mode. `ST_STOP` has all clocks off. `ST_SETTLE` waits for the oscillator to settle after stop. The named transitions are:
- run→wait on `wait_req`.
- run→stop on `stop_req`, which wins when both requests arrive together.
- wait→run on a qualified wake.
- stop→settle on a qualified wake.
- settle→run when the settle counter expires after `SETTLE_CYC` cycles.
- any state→run on reset.

A qualified wake is either of:
- the non-maskable request `xirq_pend`;
- a maskable source `i` with `irq_pend[i]` and `irq_en[i]` set while the global mask `gmask` is 0.

Top module: `lpm_ctrl`

## Requirements
- R1: An active-low reset forces the block to run in the same cycle: `mode`=00, all four clock enables 1, `bus_rd_req`=0.
- R2: In run, `wait_req` with `stop_req` low gives wait one clock later. In wait, `mode`=01, `cpu_clk_en`=0, `osc_en`=1 and `per_clk_en`=1.
- R3: In wait, `tmr_clk_en` is 0 exactly when `gmask`=1 and `wdog_dis`=1, and 1 otherwise.
- R4: In wait, `bus_rd_req`=1 on every cycle and `bus_addr` equals `stack_addr`. In any other state, `bus_rd_req`=0 and `bus_addr`=0.
- R5: In run, `stop_req` gives stop one clock later, even when `wait_req` is also high. In stop, `mode`=10 and all four clock enables are 0.
- R6: A wake qualifies when `xirq_pend`=1, whatever the value of `gmask`. It also qualifies when, for some bit `i`, `irq_pend[i]`=1 and `irq_en[i]`=1 while `gmask`=0. Nothing else qualifies.
- R7: A qualified wake in wait gives run, with all clocks enabled, one clock later.
- R8: A qualified wake in stop enters settle one clock later. Settle lasts exactly `SETTLE_CYC` cycles with `mode`=10, `osc_en`=1 and the other enables 0. The block then returns to run.
- R9: Either request in wait, stop or settle is ignored, and a wake in run has no effect.
- R10: `mode` is 00 for run, 01 for wait and 10 for stop or settle. It never takes 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_req | input | 1 | One-cycle request to enter wait |
| stop_req | input | 1 | One-cycle request to enter stop |
| irq_pend | input | NUM_SRC | Pending flags of the maskable sources |
| irq_en | input | NUM_SRC | Per-source enable bits |
| xirq_pend | input | 1 | Non-maskable interrupt pending |
| gmask | input | 1 | Global interrupt mask (1 = masked) |
| wdog_dis | input | 1 | Watchdog disable bit |
| stack_addr | input | AW | Address of the stacked status register |
| cpu_clk_en | output | 1 | CPU clock enable |
| tmr_clk_en | output | 1 | Free-running timer clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| bus_rd_req | output | 1 | Dummy read request during wait |
| bus_addr | output | AW | Dummy read address |
| mode | output | 2 | Mode indicator |

## Verification
The assertions check the following on every cycle:
- entry into wait and stop;
- the clock pattern in wait;
- the timer clock staying on while the mask is clear;
- the dummy read address;
- the fact that wait holds until a qualified wake;
- the bound on the settle counter;
- the legal mode codes.

The full truth table of the wake qualifier, the exact length of settle, the asynchronous reset and the requests ignored outside run can only be shown by the bench's scenarios. For that, the bench sweeps every combination of the pending flags, the enables, the mask and the non-maskable line in wait. It also sweeps all four mask/watchdog pairs for the timer gate.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'b00,
        ST_WAIT   = 2'b01,
        ST_STOP   = 2'b10,
        ST_SETTLE = 2'b11
    } lpm_state_e;

    localparam logic [1:0] MODE_RUN  = 2'b00;
    localparam logic [1:0] MODE_WAIT = 2'b01;
    localparam logic [1:0] MODE_STOP = 2'b10;

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
    parameter int NUM_SRC = 3
) (
    input  logic [NUM_SRC-1:0] src_pend,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               gmask,
    input  logic               xirq,
    output logic               wake
);

    logic [NUM_SRC-1:0] src_live;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_live[g] = src_pend[g] & src_en[g] & ~gmask;
    end

    assign wake = xirq | (|src_live);

endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);

    localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOAD_VAL;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD_VAL);

    p_load_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == LOAD_VAL);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int NUM_SRC    = 3,
    parameter int AW         = 16,
    parameter int SETTLE_CYC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wait_req,
    input  logic               stop_req,
    input  logic [NUM_SRC-1:0] irq_pend,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               xirq_pend,
    input  logic               gmask,
    input  logic               wdog_dis,
    input  logic [AW-1:0]      stack_addr,
    output logic               cpu_clk_en,
    output logic               tmr_clk_en,
    output logic               per_clk_en,
    output logic               osc_en,
    output logic               bus_rd_req,
    output logic [AW-1:0]      bus_addr,
    output logic [1:0]         mode
);

    lpm_state_e state, state_nx;
    logic       wake;
    logic       settle_done;
    logic       settle_load;

    lpm_wake_qual #(.NUM_SRC(NUM_SRC)) wake_i (
        .src_pend (irq_pend),
        .src_en   (irq_en),
        .gmask    (gmask),
        .xirq     (xirq_pend),
        .wake     (wake)
    );

    assign settle_load = (state == ST_STOP) && wake;

    lpm_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) settle_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (settle_load),
        .run   (state == ST_SETTLE),
        .done  (settle_done)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (stop_req)      state_nx = ST_STOP;
                else if (wait_req) state_nx = ST_WAIT;
            end
            ST_WAIT:   if (wake)        state_nx = ST_RUN;
            ST_STOP:   if (wake)        state_nx = ST_SETTLE;
            ST_SETTLE: if (settle_done) state_nx = ST_RUN;
            default:                    state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        cpu_clk_en = 1'b1;
        tmr_clk_en = 1'b1;
        per_clk_en = 1'b1;
        osc_en     = 1'b1;
        bus_rd_req = 1'b0;
        bus_addr   = '0;
        mode       = MODE_RUN;
        unique case (state)
            ST_RUN: begin
            end
            ST_WAIT: begin
                cpu_clk_en = 1'b0;
                tmr_clk_en = ~(gmask & wdog_dis);
                bus_rd_req = 1'b1;
                bus_addr   = stack_addr;
                mode       = MODE_WAIT;
            end
            ST_STOP: begin
                cpu_clk_en = 1'b0;
                tmr_clk_en = 1'b0;
                per_clk_en = 1'b0;
                osc_en     = 1'b0;
                mode       = MODE_STOP;
            end
            ST_SETTLE: begin
                cpu_clk_en = 1'b0;
                tmr_clk_en = 1'b0;
                per_clk_en = 1'b0;
                mode       = MODE_STOP;
            end
            default: begin
            end
        endcase
    end

    p_wait_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && wait_req && !stop_req) |=> mode == MODE_WAIT);

    p_wait_clocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WAIT) |-> (!cpu_clk_en && osc_en && per_clk_en));

    p_tmr_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WAIT && !gmask) |-> tmr_clk_en);

    p_wait_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WAIT) |-> (bus_rd_req && bus_addr == stack_addr));

    p_no_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_WAIT) |-> !bus_rd_req);

    p_stop_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && stop_req) |=> (mode == MODE_STOP && !osc_en && !cpu_clk_en));

    p_xirq_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WAIT && xirq_pend) |=> (mode == MODE_RUN && cpu_clk_en));

    p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !wake) |=> mode == MODE_WAIT);

    p_mode_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);

endmodule

// File: tb/lpm_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_ctrl_tb_top;

    localparam int NS = 3;
    localparam int AW = 16;
    localparam int SC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic          wait_req = 1'b0, stop_req = 1'b0;
    logic [NS-1:0] irq_pend = '0, irq_en = '0;
    logic          xirq_pend = 1'b0, gmask = 1'b0, wdog_dis = 1'b0;
    logic [AW-1:0] stack_addr = '0;
    logic          cpu_clk_en, tmr_clk_en, per_clk_en, osc_en, bus_rd_req;
    logic [AW-1:0] bus_addr;
    logic [1:0]    mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lpm_ctrl #(.NUM_SRC(NS), .AW(AW), .SETTLE_CYC(SC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
        .irq_pend(irq_pend), .irq_en(irq_en), .xirq_pend(xirq_pend),
        .gmask(gmask), .wdog_dis(wdog_dis), .stack_addr(stack_addr),
        .cpu_clk_en(cpu_clk_en), .tmr_clk_en(tmr_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .bus_rd_req(bus_rd_req), .bus_addr(bus_addr), .mode(mode)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int clk_vec();
        return {cpu_clk_en, tmr_clk_en, per_clk_en, osc_en};
    endfunction

    task automatic clear_in();
        wait_req = 0; stop_req = 0; irq_pend = '0; irq_en = '0; xirq_pend = 0;
    endtask

    task automatic pulse_wait();
        wait_req = 1; tick(); wait_req = 0;
    endtask

    task automatic pulse_xirq();
        xirq_pend = 1; tick(); xirq_pend = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #1 rst_n = 0;
        #1;
        // R1: reset state
        chk(mode == 2'b00, "R1 reset mode", mode, 0);
        chk(clk_vec() == 15, "R1 reset clocks", clk_vec(), 15);
        chk(bus_rd_req == 0, "R1 reset bus", bus_rd_req, 0);
        tick(); tick();
        rst_n = 1;
        tick();

        // R9: wake in run has no effect
        pulse_xirq();
        chk(mode == 2'b00 && clk_vec() == 15, "R9 wake in run", mode, 0);

        // Sweep: all pend/en/gmask/xirq combos from wait (R2,R3,R4,R6,R7)
        for (int c = 0; c < 256; c++) begin
            bit g, x, wd, exp_wake;
            logic [NS-1:0] p, e;
            p = c[2:0]; e = c[5:3]; g = c[6]; x = c[7]; wd = c[1] ^ c[4];
            gmask = g; wdog_dis = wd; stack_addr = AW'(c * 257 + 3);
            pulse_wait();
            chk(mode == 2'b01, "R2 wait mode", mode, 1);
            chk(!cpu_clk_en && osc_en && per_clk_en, "R2 wait clocks", clk_vec(), 3);
            chk(tmr_clk_en == !(g && wd), "R3 timer gate", tmr_clk_en, !(g && wd));
            chk(bus_rd_req && bus_addr == AW'(c * 257 + 3), "R4 dummy read", bus_addr, c * 257 + 3);
            tick();
            chk(bus_rd_req && mode == 2'b01, "R4 repeated read", bus_rd_req, 1);
            irq_pend = p; irq_en = e; xirq_pend = x;
            exp_wake = x || (!g && ((p & e) != 0));
            tick();
            clear_in();
            chk(mode == (exp_wake ? 2'b00 : 2'b01), "R6 wake qualify", mode, exp_wake ? 0 : 1);
            if (exp_wake) begin
                chk(clk_vec() == 15 && !bus_rd_req, "R7 wait exit clocks", clk_vec(), 15);
                chk(bus_addr == 0, "R4 addr outside wait", bus_addr, 0);
            end else begin
                pulse_xirq();
                chk(mode == 2'b00, "R7 xirq exit", mode, 0);
            end
        end

        // R9: requests in wait ignored
        gmask = 0; wdog_dis = 0;
        pulse_wait();
        stop_req = 1; wait_req = 1; tick(); clear_in();
        chk(mode == 2'b01, "R9 stop_req in wait", mode, 1);
        pulse_xirq();

        // R5: stop wins over simultaneous wait
        stop_req = 1; wait_req = 1; tick(); clear_in();
        chk(mode == 2'b10, "R5 stop mode", mode, 2);
        chk(clk_vec() == 0 && !bus_rd_req, "R5 stop clocks", clk_vec(), 0);

        // R6/R9 in stop: non-qualified sources and requests
        gmask = 1; irq_pend = '1; irq_en = '1; wait_req = 1; tick(); clear_in();
        chk(mode == 2'b10 && !osc_en, "R6 masked in stop", mode, 2);
        gmask = 0; irq_pend = 3'b010; irq_en = 3'b101; tick(); clear_in();
        chk(mode == 2'b10 && !osc_en, "R6 disabled src in stop", mode, 2);

        // R8: wake from stop via enabled source, settle length
        irq_pend = 3'b100; irq_en = 3'b100; tick(); clear_in();
        for (int k = 1; k <= SC; k++) begin
            chk(mode == 2'b10 && osc_en && !cpu_clk_en && !per_clk_en, "R8 settle", mode, 2);
            if (k == 3) wait_req = 1;  // R9: ignored in settle
            else wait_req = 0;
            tick();
        end
        wait_req = 0;
        chk(mode == 2'b00 && clk_vec() == 15, "R8 settle end", mode, 0);
        tick();
        chk(mode == 2'b00, "R9 request in settle ignored", mode, 0);

        // R8: xirq wakes stop even with gmask set
        gmask = 1;
        stop_req = 1; tick(); stop_req = 0;
        pulse_xirq();
        chk(mode == 2'b10 && osc_en, "R8 xirq stop wake", osc_en, 1);
        repeat (SC) tick();
        chk(mode == 2'b00, "R8 run after settle", mode, 0);
        gmask = 0;

        // R1: async reset out of wait, mid-cycle
        pulse_wait();
        #1 rst_n = 0; #0.5;
        chk(mode == 2'b00 && clk_vec() == 15 && !bus_rd_req, "R1 reset from wait", mode, 0);
        tick(); rst_n = 1; tick();
        chk(mode == 2'b00, "R10 run code after reset", mode, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule